// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block is the host side of an external 12-bit successive-approximation converter with a parallel output bus. It drives the converter's control pins: a chip-enable strobe, an active-low select, a read/convert select, a byte address and a word-width pin. It then collects the conversion result. When idle, it accepts one request. A request states whether the conversion is the short 8-bit kind or the full 12-bit kind, and whether the result is fetched as one 12-bit word or as two 8-bit bus transfers.

For each request the sequencer performs these steps in order. It issues a convert strobe, then watches the converter's busy line until it has risen and fallen again. It then runs one or two read strobes and presents the assembled 12-bit result with a one-cycle valid pulse. Every pin interval is a nanosecond parameter converted to whole clock cycles by rounding up. These intervals are the setup of the select lines before the strobe, the strobe width, the access time before data is sampled, and the quiet time after the strobe during which the bus floats. A bounded wait on the busy line ends a conversion that never completes: the sequencer gives an error pulse instead of a result.

With the default parameters and a 5 ns clock, the setup and convert-strobe intervals are 10 cycles each, the read strobe and float intervals are 30 cycles each, and the busy timeout is 6000 cycles.

Top module: `sarHost`

## Requirements
- R1: After reset the strobe `adcCe` is low, `adcCsN` is high, `adcRc` is high, `adcAo` is low, `reqReady` is high, and `resValid` and `resTimeout` are low.
- R2: A convert strobe has `adcCsN` low and `adcRc` low for exactly SETUP_CYC cycles with `adcCe` low before `adcCe` rises. `adcCe` then stays high for exactly CE_CYC cycles, and `adcCsN` and `adcRc` do not change while it is high.
- R3: During the convert strobe `adcAo` equals the `reqShort` value of the accepted request (1 selects the 8-bit conversion) and is stable while `adcCe` is high.
- R4: No read strobe starts until the busy input `adcStatus` has been seen high after the convert strobe began and has then returned low. `adcStatus` is low whenever a read strobe rises.
- R5: A read strobe has `adcCsN` low and `adcRc` high for exactly SETUP_CYC cycles before `adcCe` rises. `adcCe` stays high for exactly ACCESS_CYC cycles, and the bus is sampled at the end of the last of those cycles.
- R6: With `reqByteMode` = 0, `adcMode12` is high during the read, a single read strobe is made with `adcAo` low, and `resData` equals the 12-bit bus value.
- R7: With `reqByteMode` = 1, `adcMode12` is low and two read strobes are made, the first with `adcAo` = 0 and the second with `adcAo` = 1. The result is bus[11:4] of the first transfer followed by bus[11:8] of the second transfer as bits [3:0]. Bus bits [3:0] are ignored in both transfers.
- R8: After every read strobe falls, `adcCe` stays low and `adcCsN` stays high for FLOAT_CYC cycles before the next strobe or the result. `resValid` rises exactly FLOAT_CYC+1 cycles into the low period, counting the first low cycle as 1.
- R9: `resValid` is a single-cycle pulse, `resData` changes only together with it, and `reqReady` is high again in the cycle of the pulse.
- R10: If the busy line has not completed its high-then-low sequence within TIMEOUT_CYC cycles, `resTimeout` pulses for one cycle exactly TIMEOUT_CYC cycles after the convert strobe rose. In that case no read strobe and no `resValid` follow, and the sequencer returns to idle.
- R11: A request made while `reqReady` is low has no effect: no further convert strobe is made, and the running transaction completes with its original read format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request, taken only while idle |
| reqShort | input | 1 | 1 = 8-bit conversion, 0 = 12-bit conversion |
| reqByteMode | input | 1 | 1 = fetch result as two byte transfers, 0 = one word transfer |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| adcCe | output | 1 | Converter enable strobe, active high |
| adcCsN | output | 1 | Converter select, active low |
| adcRc | output | 1 | 1 = read, 0 = convert |
| adcAo | output | 1 | Conversion length during convert, byte select during byte reads |
| adcMode12 | output | 1 | 1 = all 12 bus lines, 0 = 8-line byte transfers |
| adcStatus | input | 1 | Converter busy line |
| adcData | input | DATA_W | Converter output bus |
| resData | output | DATA_W | Assembled result |
| resValid | output | 1 | One-cycle result strobe |
| resTimeout | output | 1 | One-cycle busy-timeout error strobe |

## Verification
All pins are registered from the next state, so each strobe edge appears in the same cycle the sequencer changes phase. The bench model of the converter places valid data on the bus only in the last cycle of the read strobe, and places a decoy value before that. A capture one cycle early therefore returns the decoy. `resValid` and `resTimeout` lag the deciding state by one register. They are therefore expected exactly FLOAT_CYC+1 cycles after the last strobe falls and exactly TIMEOUT_CYC cycles after the convert strobe rises. A pin monitor counts these distances one sample per cycle, and the checks compare them for equality rather than with a bound.

// File: rtl/sarHostPkg.sv
package sarHostPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSETUP,
    ST_CPULSE,
    ST_CWAIT,
    ST_RSETUP,
    ST_RPULSE,
    ST_RFLOAT
  } sarState_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic capture;     // sample the bus this cycle
    logic secondByte;  // capture belongs to the low-order transfer
    logic wordMode;    // capture is a full-width transfer
    logic finish;      // result complete, publish it
    logic fail;        // busy wait expired
  } dpStrobe_t;

  // round a nanosecond interval up to whole clock cycles, never below one
  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sarHostCtrl.sv
module sarHostCtrl
  import sarHostPkg::*;
#(
  parameter int SETUP_CYC   = 10,
  parameter int CE_CYC      = 10,
  parameter int ACCESS_CYC  = 30,
  parameter int FLOAT_CYC   = 30,
  parameter int TIMEOUT_CYC = 6000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqShort,
  input  logic       reqByteMode,
  input  logic       adcStatus,
  output logic       reqReady,
  output logic       adcCe,
  output logic       adcCsN,
  output logic       adcRc,
  output logic       adcAo,
  output logic       adcMode12,
  output dpStrobe_t  strobe
);

  localparam int PIN_MAX = maxOf(maxOf(SETUP_CYC, CE_CYC), maxOf(ACCESS_CYC, FLOAT_CYC));
  localparam int CNT_W   = $clog2(PIN_MAX + 1);
  localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);

  sarState_t        state, nextState;
  logic [CNT_W-1:0] phaseCnt;
  logic [TMO_W-1:0] tmoCnt;
  logic             statusSeen;
  logic             byteIdx, nextByteIdx;
  logic             shortQ, byteModeQ;
  logic             phaseDone, convDone, tmoExpired, moreBytes;

  assign phaseDone  = (phaseCnt == '0);
  assign convDone   = statusSeen && !adcStatus;
  assign tmoExpired = (tmoCnt == '0);
  assign moreBytes  = byteModeQ && !byteIdx;

  function automatic logic [CNT_W-1:0] phaseLoad(input sarState_t s);
    case (s)
      ST_CSETUP, ST_RSETUP: phaseLoad = CNT_W'(SETUP_CYC - 1);
      ST_CPULSE:            phaseLoad = CNT_W'(CE_CYC - 1);
      ST_RPULSE:            phaseLoad = CNT_W'(ACCESS_CYC - 1);
      ST_RFLOAT:            phaseLoad = CNT_W'(FLOAT_CYC - 1);
      default:              phaseLoad = '0;
    endcase
  endfunction

  // phase sequencing
  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (reqValid)  nextState = ST_CSETUP;
      ST_CSETUP: if (phaseDone) nextState = ST_CPULSE;
      ST_CPULSE: if (phaseDone) nextState = ST_CWAIT;
      ST_CWAIT: begin
        if (convDone)        nextState = ST_RSETUP;
        else if (tmoExpired) nextState = ST_IDLE;
      end
      ST_RSETUP: if (phaseDone) nextState = ST_RPULSE;
      ST_RPULSE: if (phaseDone) nextState = ST_RFLOAT;
      ST_RFLOAT: if (phaseDone) nextState = moreBytes ? ST_RSETUP : ST_IDLE;
      default:                  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    nextByteIdx = byteIdx;
    if (state == ST_IDLE)                            nextByteIdx = 1'b0;
    else if (state == ST_RFLOAT && phaseDone && moreBytes) nextByteIdx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      tmoCnt     <= '0;
      statusSeen <= 1'b0;
      byteIdx    <= 1'b0;
      shortQ     <= 1'b0;
      byteModeQ  <= 1'b0;
    end else begin
      state   <= nextState;
      byteIdx <= nextByteIdx;
      if (state != nextState)
        phaseCnt <= phaseLoad(nextState);
      else if (!phaseDone)
        phaseCnt <= phaseCnt - 1'b1;
      // timeout window opens on the convert strobe's rising edge
      if (nextState == ST_CPULSE && state != ST_CPULSE)
        tmoCnt <= TMO_W'(TIMEOUT_CYC - 1);
      else if ((state == ST_CPULSE || state == ST_CWAIT) && !tmoExpired)
        tmoCnt <= tmoCnt - 1'b1;
      if (state == ST_IDLE)
        statusSeen <= 1'b0;
      else if ((state == ST_CPULSE || state == ST_CWAIT) && adcStatus)
        statusSeen <= 1'b1;
      if (state == ST_IDLE && reqValid) begin
        shortQ    <= reqShort;
        byteModeQ <= reqByteMode;
      end
    end
  end

  // pins are registered from the next phase so they switch glitch-free
  logic nextShort, nextByteMode;
  assign nextShort    = (state == ST_IDLE) ? reqShort    : shortQ;
  assign nextByteMode = (state == ST_IDLE) ? reqByteMode : byteModeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcCe     <= 1'b0;
      adcCsN    <= 1'b1;
      adcRc     <= 1'b1;
      adcAo     <= 1'b0;
      adcMode12 <= 1'b1;
    end else begin
      adcCe  <= (nextState == ST_CPULSE) || (nextState == ST_RPULSE);
      adcCsN <= !((nextState == ST_CSETUP) || (nextState == ST_CPULSE) ||
                  (nextState == ST_RSETUP) || (nextState == ST_RPULSE));
      adcRc  <= !((nextState == ST_CSETUP) || (nextState == ST_CPULSE));
      if (nextState == ST_CSETUP || nextState == ST_CPULSE)
        adcAo <= nextShort;
      else if (nextState == ST_RSETUP || nextState == ST_RPULSE)
        adcAo <= byteModeQ && nextByteIdx;
      else
        adcAo <= 1'b0;
      if (state == ST_IDLE && reqValid)
        adcMode12 <= !nextByteMode;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.capture    = (state == ST_RPULSE) && phaseDone;
    strobe.secondByte = byteIdx;
    strobe.wordMode   = !byteModeQ;
    strobe.finish     = (state == ST_RFLOAT) && phaseDone && !moreBytes;
    strobe.fail       = (state == ST_CWAIT) && tmoExpired && !convDone;
  end

  AST_CE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    adcCe |-> !adcCsN); // R2
  AST_RC_HELD_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (adcCe && $past(adcCe)) |-> $stable(adcRc)); // R2
  AST_AO_HELD_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (adcCe && $past(adcCe)) |-> $stable(adcAo)); // R3
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(adcCe) && adcRc) |-> !adcStatus); // R4

endmodule

// File: rtl/sarHostDatapath.sv
module sarHostDatapath
  import sarHostPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] adcData,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              resTimeout
);

  localparam int LO_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] assembly;

  // byte transfers arrive left-justified on the upper bus lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      assembly <= '0;
    end else if (strobe.capture) begin
      if (strobe.wordMode)
        assembly <= adcData;
      else if (!strobe.secondByte)
        assembly[DATA_W-1 -: BYTE_W] <= adcData[DATA_W-1 -: BYTE_W];
      else
        assembly[LO_W-1:0] <= adcData[DATA_W-1 -: LO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData    <= '0;
      resValid   <= 1'b0;
      resTimeout <= 1'b0;
    end else begin
      resValid   <= strobe.finish;
      resTimeout <= strobe.fail;
      if (strobe.finish)
        resData <= assembly;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(resData)); // R9
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && resTimeout)); // R10

endmodule

// File: rtl/sarHost.sv
module sarHost
  import sarHostPkg::*;
#(
  parameter int CLK_NS     = 5,
  parameter int SETUP_NS   = 50,
  parameter int CE_NS      = 50,
  parameter int ACCESS_NS  = 150,
  parameter int FLOAT_NS   = 150,
  parameter int TIMEOUT_NS = 30000,
  parameter int DATA_W     = 12,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqShort,
  input  logic              reqByteMode,
  output logic              reqReady,
  output logic              adcCe,
  output logic              adcCsN,
  output logic              adcRc,
  output logic              adcAo,
  output logic              adcMode12,
  input  logic              adcStatus,
  input  logic [DATA_W-1:0] adcData,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              resTimeout
);

  localparam int SETUP_CYC   = nsToCycles(SETUP_NS, CLK_NS);
  localparam int CE_CYC      = nsToCycles(CE_NS, CLK_NS);
  // a read strobe is never narrower than the minimum strobe width
  localparam int ACCESS_CYC  = maxOf(nsToCycles(ACCESS_NS, CLK_NS), CE_CYC);
  localparam int FLOAT_CYC   = nsToCycles(FLOAT_NS, CLK_NS);
  localparam int TIMEOUT_CYC = maxOf(nsToCycles(TIMEOUT_NS, CLK_NS), CE_CYC + 1);

  dpStrobe_t strobe;

  sarHostCtrl #(
    .SETUP_CYC  (SETUP_CYC),
    .CE_CYC     (CE_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .FLOAT_CYC  (FLOAT_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqShort   (reqShort),
    .reqByteMode(reqByteMode),
    .adcStatus  (adcStatus),
    .reqReady   (reqReady),
    .adcCe      (adcCe),
    .adcCsN     (adcCsN),
    .adcRc      (adcRc),
    .adcAo      (adcAo),
    .adcMode12  (adcMode12),
    .strobe     (strobe)
  );

  sarHostDatapath #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .adcData   (adcData),
    .resData   (resData),
    .resValid  (resValid),
    .resTimeout(resTimeout)
  );

endmodule

// File: tb/sarHost_bench.sv
module sarHost_bench;

  localparam int SETUP_CYC   = 10;
  localparam int CE_CYC      = 10;
  localparam int ACCESS_CYC  = 30;
  localparam int FLOAT_CYC   = 30;
  localparam int TIMEOUT_CYC = 6000;

  // {byteMode, short, convLen[7:0], data[11:0]}
  localparam int NVEC = 8;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd60, 12'hABC},
    {1'b1, 1'b0, 8'd60, 12'hABC},
    {1'b1, 1'b1, 8'd40, 12'hF0F},
    {1'b0, 1'b1, 8'd40, 12'h001},
    {1'b1, 1'b0, 8'd60, 12'hFFF},
    {1'b0, 1'b0, 8'd3,  12'h000},
    {1'b1, 1'b0, 8'd3,  12'h8A5},
    {1'b0, 1'b1, 8'd20, 12'h7E1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqShort = 1'b0, reqByteMode = 1'b0;
  logic reqReady, adcCe, adcCsN, adcRc, adcAo, adcMode12, adcStatus;
  logic [11:0] adcData, resData;
  logic resValid, resTimeout;

  always #2.5ns clk = ~clk;

  sarHost u_sarHost (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqShort(reqShort),
    .reqByteMode(reqByteMode), .reqReady(reqReady), .adcCe(adcCe),
    .adcCsN(adcCsN), .adcRc(adcRc), .adcAo(adcAo), .adcMode12(adcMode12),
    .adcStatus(adcStatus), .adcData(adcData), .resData(resData),
    .resValid(resValid), .resTimeout(resTimeout)
  );

  // converter model
  logic [7:0]  convLen = 8'd60;
  logic [11:0] word = 12'h000;
  logic        noStatus = 1'b0;
  logic        ceM = 1'b0;
  logic [8:0]  busyLeft = '0;
  int          rdCnt = 0;
  logic [11:0] lane;

  always @(posedge clk) begin
    ceM <= adcCe;
    if (!rstN) busyLeft <= '0;
    else if (adcCe && !ceM && !adcCsN && !adcRc && !noStatus) busyLeft <= {1'b0, convLen} + 9'd2;
    else if (busyLeft != '0) busyLeft <= busyLeft - 1'b1;
    if (adcCe && adcRc && !adcCsN) rdCnt <= rdCnt + 1;
    else rdCnt <= 0;
  end

  assign adcStatus = (busyLeft != '0) && (busyLeft <= {1'b0, convLen});
  assign lane = adcMode12 ? word : (adcAo ? {word[3:0], 4'h0, 4'hA} : {word[11:4], 4'hA});
  assign adcData = (adcCe && adcRc && !adcCsN) ? ((rdCnt >= ACCESS_CYC - 1) ? lane : 12'h5A5) : 12'h000;

  int nChecks = 0, nErr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin monitor, sampled 1 ns after each rising edge
  logic expShort = 1'b0;
  logic ceQ = 1'b0, rcPrev = 1'b1, rcAtRise = 1'b0, aoAtRise = 1'b0, heldBad = 1'b0;
  int   setupRun = 0, highRun = 0, sinceFall = 0, sinceConv = 0;
  int   convRises = 0, readCnt = 0;
  logic [1:0] readAo = '0;
  logic modeAtRead = 1'b0;

  always begin
    @(posedge clk);
    #1ns;
    if (rstN) begin
      if (adcCe && !ceQ) begin
        chk(setupRun == SETUP_CYC, adcRc ? "R5 select setup" : "R2 select setup", setupRun, SETUP_CYC);
        rcAtRise = adcRc; aoAtRise = adcAo; heldBad = 1'b0; highRun = 1;
        if (!adcRc) begin
          convRises++; sinceConv = 0;
          chk(adcAo == expShort, "R3 convert length select", adcAo, expShort);
        end else begin
          chk(!adcStatus, "R4 read while busy", adcStatus, 0);
          if (readCnt > 0) chk(sinceFall >= FLOAT_CYC, "R8 float before next read", sinceFall, FLOAT_CYC);
          if (readCnt < 2) readAo[readCnt] = adcAo;
          modeAtRead = adcMode12;
          readCnt++;
        end
      end else if (adcCe) begin
        highRun++;
        if (adcCsN || adcRc != rcAtRise || adcAo != aoAtRise) heldBad = 1'b1;
      end else if (ceQ) begin
        chk(highRun == (rcAtRise ? ACCESS_CYC : CE_CYC), rcAtRise ? "R5 strobe width" : "R2 strobe width",
            highRun, rcAtRise ? ACCESS_CYC : CE_CYC);
        chk(!heldBad, rcAtRise ? "R5 lines held" : "R2 lines held", heldBad, 0);
        sinceFall = 1;
      end else begin
        sinceFall++;
      end
      if (!adcCe) begin
        if (ceQ) begin
          setupRun = 0;
        end else if (!adcCsN) begin
          setupRun = (adcRc == rcPrev) ? setupRun + 1 : 1;
        end else begin
          setupRun = 0;
        end
      end else begin
        setupRun = 0;
      end
      if (!(adcCe && !ceQ && !adcRc)) sinceConv++;
      rcPrev = adcRc;
      ceQ = adcCe;
    end
  end

  task automatic request(input logic bm, input logic sh);
    @(negedge clk);
    convRises = 0; readCnt = 0; readAo = '0; expShort = sh;
    reqValid = 1'b1; reqByteMode = bm; reqShort = sh;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // waits for a result; returns 1 on resValid, 0 on resTimeout
  task automatic waitDone(output bit gotValid, output bit gotAny);
    gotValid = 0; gotAny = 0;
    for (int i = 0; i < TIMEOUT_CYC + 500; i++) begin
      @(negedge clk);
      if (resValid || resTimeout) begin
        gotValid = resValid; gotAny = 1;
        break;
      end
    end
  endtask

  task automatic checkResult(input logic bm, input logic [11:0] exp, input string tagSfx);
    bit v, a;
    waitDone(v, a);
    chk(v, {bm ? "R7 result seen " : "R6 result seen ", tagSfx}, v, 1);
    if (v) begin
      chk(resData == exp, bm ? "R7 assembled value" : "R6 word value", resData, exp);
      chk(readCnt == (bm ? 2 : 1), bm ? "R7 two transfers" : "R6 one transfer", readCnt, bm ? 2 : 1);
      chk(readAo == (bm ? 2'b10 : 2'b00), bm ? "R7 byte order" : "R6 address low", readAo, bm ? 2 : 0);
      chk(modeAtRead == !bm, bm ? "R7 width pin" : "R6 width pin", modeAtRead, !bm);
      chk(sinceFall == FLOAT_CYC + 1, "R8 float before result", sinceFall, FLOAT_CYC + 1);
      chk(reqReady, "R9 ready with result", reqReady, 1);
      chk(convRises == 1, "R2 one convert strobe", convRises, 1);
      @(negedge clk);
      chk(!resValid, "R9 valid single cycle", resValid, 0);
      chk(resData == exp, "R9 result held", resData, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    bit v, a;
    repeat (4) @(negedge clk);
    // R1 reset state, sampled while reset is held and after release
    chk(!adcCe && adcCsN && adcRc && !adcAo, "R1 pins in reset", {adcCe, adcCsN, adcRc, adcAo}, 4'b0110);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !resValid && !resTimeout, "R1 status after reset", {reqReady, resValid, resTimeout}, 3'b100);

    for (int k = 0; k < NVEC; k++) begin
      word = VEC[k][11:0]; convLen = VEC[k][19:12];
      request(VEC[k][21], VEC[k][20]);
      chk(!reqReady, "R11 busy after accept", reqReady, 0);
      checkResult(VEC[k][21], VEC[k][11:0], "vector");
    end

    // R11: requests while busy must not start a second conversion
    word = 12'h3C6; convLen = 8'd60;
    request(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    reqValid = 1'b1; reqByteMode = 1'b1; reqShort = 1'b1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    checkResult(1'b0, 12'h3C6, "R11 busy request");
    repeat (60) @(negedge clk);
    chk(convRises == 1, "R11 no extra convert", convRises, 1);
    chk(reqReady, "R11 idle after", reqReady, 1);

    // R10: busy line never rises
    noStatus = 1'b1;
    request(1'b1, 1'b0);
    waitDone(v, a);
    chk(a && !v, "R10 timeout instead of result", {a, v}, 2'b10);
    chk(sinceConv == TIMEOUT_CYC, "R10 timeout distance", sinceConv, TIMEOUT_CYC);
    chk(readCnt == 0, "R10 no read strobe", readCnt, 0);
    @(negedge clk);
    chk(!resTimeout && reqReady, "R10 single pulse and idle", {resTimeout, reqReady}, 2'b01);
    noStatus = 1'b0;

    // recovery after the timeout
    word = 12'h9D2; convLen = 8'd30;
    request(1'b1, 1'b1);
    checkResult(1'b1, 12'h9D2, "after timeout");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule